// File: doc/BRIEF.md
# Clock Domain Frequency Readback Decoder

This block works out the present output frequency, in kHz, of one clock domain from a frozen snapshot of that domain's configuration words. The snapshot holds the following items:

- a source-select word and its divider control, which choose a fixed reference, the crystal or one of two spread-PLL VCOs;
- a PLL enable/control word and a coefficient word;
- a domain mux bit, which routes either the PLL or the source path to the output;
- a post-divider word for the domain.

All dividers count in half steps, so a divider field `f` scales a frequency by `2/(f+2)`.

A caller presents the words and pulses `start_i`. The block registers every input on that pulse and walks the chain through the source, the PLL multiply, the PLL divide and the post divider. All divisions share one sequential restoring divider. It then raises `done_o` for one cycle. The result on `freq_khz_o` stays unchanged until the next computation completes. A computation costs up to four divider passes of `PROD_W` cycles each. Steps that need no division are skipped.

Top module: `clkrd_freq_readback`

## Requirements
- R1: After reset, `done_o` is 0 and `freq_khz_o` is 0.
- R2: With source code 0 (source word bits [1:0]), the source frequency is the crystal. When source word bits [17:16] are both 1, it is a fixed 108000 instead.
- R3: Source code 2 gives a fixed 100000. Source code 1 gives 0.
- R4: Source code 3 takes the VCO chosen by source word bit 8 (1 = second VCO) and yields 2*VCO/sdiv. sdiv is 2 unless bit 31 of the source divider word is set. In that case sdiv is the 6-bit field plus 2, taken from bits [13:8] when source bit 8 is 1 and from bits [5:0] otherwise.
- R5: With the PLL reference select at 0, the PLL is crystal-fed. Its output is crystal*N/M, with N in coefficient bits [15:8] and M in bits [7:0]. The P field (bits [21:16]) is treated as 1.
- R6: With the PLL reference select at 1, the PLL is fed from the source result of R2 to R4. Its output is ((ref*N)/M)/P, each division truncating, with the product held at PROD_W bits and the final value cut to its low FREQ_W bits.
- R7: A PLL whose control word bit 0 is clear reads as 0.
- R8: A zero M, or a zero P on the source-fed PLL, makes the PLL read 0. No division by zero is started.
- R9: The domain mux bit at 1 routes the PLL to the domain and at 0 routes the source. If post word bit 31 is set, the domain output is 2*clk/(field+2), with the field taken from bits [13:8] on the PLL route and from bits [5:0] otherwise. If bit 31 is clear, the clock passes unchanged.
- R10: Each accepted start yields exactly one single-cycle `done_o`. `freq_khz_o` changes only in that cycle and holds its value otherwise.
- R11: Inputs are used as latched at the accepted start. A start or input change while a computation runs has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| pll_ctrl_i | input | 32 | PLL control word (bit 0 enable) |
| pll_coef_i | input | 32 | PLL coefficients P, N, M |
| src_word_i | input | 32 | Source-select word |
| src_div_i | input | 32 | Source divider control word |
| post_ctl_i | input | 32 | Domain post-divider word |
| use_pll_i | input | 1 | Domain mux: 1 = PLL route |
| pll_ref_sel_i | input | 1 | PLL reference: 0 = crystal, 1 = source path |
| xtal_khz_i | input | FREQ_W | Crystal frequency |
| vco0_khz_i | input | FREQ_W | First spread-PLL VCO frequency |
| vco1_khz_i | input | FREQ_W | Second spread-PLL VCO frequency |
| done_o | output | 1 | One-cycle completion pulse |
| freq_khz_o | output | FREQ_W | Computed domain frequency |

## Verification
The bench builds the block with its defaults, FREQ_W = 32 and PROD_W = 48. These bring full-range crystal values multiplied by N = 255 within reach, along with the truncation of an oversized PLL result to 32 bits. A behavioural model in 64-bit arithmetic predicts each result, and the held output is compared on every clock. The cases cover every source code, both VCO field positions, both PLL reference choices, zero M and P, a disabled PLL, post-divider field selection per route, and a start issued mid-computation.

// File: rtl/clkrd_pkg.sv
// Package: shared types and constants for the frequency readback decoder.
// Assumes 32-bit configuration words; field positions are fixed by the
// register layout that the decoder reads.
package clkrd_pkg;
    localparam int REG_W   = 32;
    localparam int COEF_W  = 8;
    localparam int FIELD_W = 6;
    localparam int FIXED_HI_KHZ  = 108000;
    localparam int FIXED_REF_KHZ = 100000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_PLLM,
        ST_PLLP,
        ST_POST
    } clkrd_state_e;

    typedef struct packed {
        logic [REG_W-1:0] pll_ctrl;
        logic [REG_W-1:0] pll_coef;
        logic [REG_W-1:0] src_word;
        logic [REG_W-1:0] src_div;
        logic [REG_W-1:0] post_ctl;
        logic             use_pll;
        logic             ref_sel;
    } clkrd_cfg_t;
endpackage

// File: rtl/clkrd_field_decode.sv
// Module: clkrd_field_decode
// Purely combinational field extraction from a latched configuration
// snapshot: source code, fixed source value, VCO choice and its half-step
// divisor, PLL coefficients with validity, and the domain post divisor.
// Assumes FREQ_W >= 17 so the fixed reference values fit.
module clkrd_field_decode
    import clkrd_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  clkrd_cfg_t        cfg,
    input  logic [FREQ_W-1:0] xtal_khz,
    input  logic [FREQ_W-1:0] vco0_khz,
    input  logic [FREQ_W-1:0] vco1_khz,
    output logic              is_vco,
    output logic [FREQ_W-1:0] fixed_khz,
    output logic [FREQ_W-1:0] vco_khz,
    output logic [FREQ_W-1:0] vco_div,
    output logic              pll_ok,
    output logic [COEF_W-1:0] pll_n,
    output logic [FREQ_W-1:0] pll_m,
    output logic [FREQ_W-1:0] pll_p,
    output logic              post_en,
    output logic [FREQ_W-1:0] post_div
);
    localparam int PADF = FREQ_W - FIELD_W;

    logic [FIELD_W-1:0] src_field;
    logic [FIELD_W-1:0] post_field;
    logic [FIELD_W-1:0] p_raw;
    logic               vco_hi;
    logic               unused_cfg_bits;

    // Source decode: fixed values for codes 0..2, VCO selection for code 3.
    always_comb begin
        vco_hi    = cfg.src_word[8];
        is_vco    = (cfg.src_word[1:0] == 2'd3);
        vco_khz   = vco_hi ? vco1_khz : vco0_khz;
        src_field = vco_hi ? cfg.src_div[13:8] : cfg.src_div[5:0];
        vco_div   = cfg.src_div[31] ? ({{PADF{1'b0}}, src_field} + FREQ_W'(2))
                                    : FREQ_W'(2);
        unique case (cfg.src_word[1:0])
            2'd0:    fixed_khz = (cfg.src_word[17:16] == 2'b11) ? FREQ_W'(FIXED_HI_KHZ)
                                                                 : xtal_khz;
            2'd2:    fixed_khz = FREQ_W'(FIXED_REF_KHZ);
            default: fixed_khz = '0;
        endcase
    end

    // PLL coefficients; the crystal-fed variant forces P to one.
    always_comb begin
        p_raw  = cfg.pll_coef[21:16];
        pll_n  = cfg.pll_coef[15:8];
        pll_m  = {{(FREQ_W-COEF_W){1'b0}}, cfg.pll_coef[7:0]};
        pll_p  = cfg.ref_sel ? {{PADF{1'b0}}, p_raw} : FREQ_W'(1);
        pll_ok = cfg.pll_ctrl[0] && (pll_m != '0) && (pll_p != '0);
    end

    // Domain post divider: field position follows the mux route.
    always_comb begin
        post_field = cfg.use_pll ? cfg.post_ctl[13:8] : cfg.post_ctl[5:0];
        post_en    = cfg.post_ctl[31];
        post_div   = {{PADF{1'b0}}, post_field} + FREQ_W'(2);
    end

    assign unused_cfg_bits = ^{cfg.pll_ctrl[31:1], cfg.pll_coef[31:22],
                               cfg.src_word[31:18], cfg.src_word[15:9], cfg.src_word[7:2],
                               cfg.src_div[30:14], cfg.src_div[7:6],
                               cfg.post_ctl[30:14], cfg.post_ctl[7:6]};
endmodule

// File: rtl/clkrd_seq_div.sv
// Module: clkrd_seq_div
// Restoring unsigned divider, one quotient bit per cycle. go_i loads a new
// problem; done_o pulses once, NUM_W cycles later, with quo_o valid and
// held until the next go. Assumes den_i is nonzero (caller guarantees).
module clkrd_seq_div #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] q;
    logic [DEN_W-1:0] r;
    logic [DEN_W-1:0] d;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             ge;

    // One restoring step: shift in next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {r, q[NUM_W-1]};
        ge      = (shifted >= {1'b0, d});
        diff    = shifted - {1'b0, d};
    end

    // Iteration control and quotient/remainder registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            q      <= '0;
            r      <= '0;
            d      <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                busy <= 1'b1;
                cnt  <= '0;
                q    <= num_i;
                r    <= '0;
                d    <= den_i;
            end else if (busy) begin
                q   <= {q[NUM_W-2:0], ge};
                r   <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                cnt <= cnt + CNT_W'(1);
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = q;

    // A finished division leaves a remainder below the divisor (R9 arithmetic).
    assert_rem_below_divisor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (r < d));

    // The controller never restarts a division in flight (R11).
    assert_go_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy);
endmodule

// File: rtl/clkrd_freq_readback.sv
// Module: clkrd_freq_readback (top)
// Latches a configuration snapshot on start_i and evaluates the domain
// frequency through source, PLL multiply/divide and post divider, reusing
// one sequential divider. done_o pulses once; freq_khz_o holds until the
// next completion. Starts arriving while busy are ignored.
module clkrd_freq_readback
    import clkrd_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PROD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       pll_ctrl_i,
    input  logic [31:0]       pll_coef_i,
    input  logic [31:0]       src_word_i,
    input  logic [31:0]       src_div_i,
    input  logic [31:0]       post_ctl_i,
    input  logic              use_pll_i,
    input  logic              pll_ref_sel_i,
    input  logic [FREQ_W-1:0] xtal_khz_i,
    input  logic [FREQ_W-1:0] vco0_khz_i,
    input  logic [FREQ_W-1:0] vco1_khz_i,
    output logic              done_o,
    output logic [FREQ_W-1:0] freq_khz_o
);
    localparam int PAD_W = PROD_W - FREQ_W;

    clkrd_state_e      state;
    clkrd_cfg_t        cfg;
    logic [FREQ_W-1:0] xtal_q, vco0_q, vco1_q;
    logic              wait_q;
    logic [FREQ_W-1:0] src_f;
    logic [FREQ_W-1:0] sclk;
    logic [PROD_W-1:0] acc;

    logic              div_go;
    logic [PROD_W-1:0] div_num;
    logic [FREQ_W-1:0] div_den;
    logic              div_done;
    logic [PROD_W-1:0] div_quo;

    logic              is_vco, pll_ok, post_en;
    logic [FREQ_W-1:0] fixed_khz, vco_khz, vco_div, pll_m, pll_p, post_div;
    logic [COEF_W-1:0] pll_n;
    logic [FREQ_W-1:0] pll_ref;
    logic [PROD_W-1:0] pll_prod;

    clkrd_field_decode #(.FREQ_W(FREQ_W)) u_decode (
        .cfg(cfg), .xtal_khz(xtal_q), .vco0_khz(vco0_q), .vco1_khz(vco1_q),
        .is_vco(is_vco), .fixed_khz(fixed_khz), .vco_khz(vco_khz), .vco_div(vco_div),
        .pll_ok(pll_ok), .pll_n(pll_n), .pll_m(pll_m), .pll_p(pll_p),
        .post_en(post_en), .post_div(post_div)
    );

    clkrd_seq_div #(.NUM_W(PROD_W), .DEN_W(FREQ_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num), .den_i(div_den),
        .done_o(div_done), .quo_o(div_quo)
    );

    // PLL reference and the widened reference*N product.
    always_comb begin
        pll_ref  = cfg.ref_sel ? src_f : xtal_q;
        pll_prod = {{PAD_W{1'b0}}, pll_ref} * {{(PROD_W-COEF_W){1'b0}}, pll_n};
    end

    // Sequencer: walks source, PLL /M, PLL /P and post divider stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cfg        <= '0;
            xtal_q     <= '0;
            vco0_q     <= '0;
            vco1_q     <= '0;
            wait_q     <= 1'b0;
            src_f      <= '0;
            sclk       <= '0;
            acc        <= '0;
            div_go     <= 1'b0;
            div_num    <= '0;
            div_den    <= '0;
            done_o     <= 1'b0;
            freq_khz_o <= '0;
        end else begin
            div_go <= 1'b0;
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    cfg    <= '{pll_ctrl: pll_ctrl_i, pll_coef: pll_coef_i,
                                src_word: src_word_i, src_div: src_div_i,
                                post_ctl: post_ctl_i, use_pll: use_pll_i,
                                ref_sel: pll_ref_sel_i};
                    xtal_q <= xtal_khz_i;
                    vco0_q <= vco0_khz_i;
                    vco1_q <= vco1_khz_i;
                    wait_q <= 1'b0;
                    state  <= ST_SRC;
                end
                ST_SRC: if (!wait_q) begin
                    if (is_vco) begin
                        div_go  <= 1'b1;
                        div_num <= {{(PAD_W-1){1'b0}}, vco_khz, 1'b0};
                        div_den <= vco_div;
                        wait_q  <= 1'b1;
                    end else begin
                        src_f <= fixed_khz;
                        state <= ST_PLLM;
                    end
                end else if (div_done) begin
                    src_f  <= div_quo[FREQ_W-1:0];
                    wait_q <= 1'b0;
                    state  <= ST_PLLM;
                end
                ST_PLLM: if (!wait_q) begin
                    if (!cfg.use_pll) begin
                        sclk  <= src_f;
                        state <= ST_POST;
                    end else if (!pll_ok) begin
                        sclk  <= '0;
                        state <= ST_POST;
                    end else begin
                        div_go  <= 1'b1;
                        div_num <= pll_prod;
                        div_den <= pll_m;
                        wait_q  <= 1'b1;
                    end
                end else if (div_done) begin
                    wait_q <= 1'b0;
                    if (cfg.ref_sel) begin
                        acc   <= div_quo;
                        state <= ST_PLLP;
                    end else begin
                        sclk  <= div_quo[FREQ_W-1:0];
                        state <= ST_POST;
                    end
                end
                ST_PLLP: if (!wait_q) begin
                    div_go  <= 1'b1;
                    div_num <= acc;
                    div_den <= pll_p;
                    wait_q  <= 1'b1;
                end else if (div_done) begin
                    sclk   <= div_quo[FREQ_W-1:0];
                    wait_q <= 1'b0;
                    state  <= ST_POST;
                end
                ST_POST: if (!wait_q) begin
                    if (post_en) begin
                        div_go  <= 1'b1;
                        div_num <= {{(PAD_W-1){1'b0}}, sclk, 1'b0};
                        div_den <= post_div;
                        wait_q  <= 1'b1;
                    end else begin
                        freq_khz_o <= sclk;
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end else if (div_done) begin
                    freq_khz_o <= div_quo[FREQ_W-1:0];
                    done_o     <= 1'b1;
                    wait_q     <= 1'b0;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // done is a single-cycle pulse (R10).
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Result moves only together with done (R10).
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(freq_khz_o));

    // No division by zero is ever launched (R8).
    assert_nonzero_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (div_den != '0));

    // Completion only comes out of a running computation (R11).
    assert_done_from_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state) == ST_POST));
endmodule

// File: tb/test_clkrd_freq_readback.sv
module test_clkrd_freq_readback;
    localparam int FREQ_W = 32;
    localparam longint unsigned M32 = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pll_ctrl = '0, pll_coef = '0, src_w = '0, src_div = '0, post_w = '0;
    logic        use_pll = 1'b0, ref_sel = 1'b0;
    logic [31:0] xtal = 32'd27000, vco0 = 32'd1620000, vco1 = 32'd2000000;
    logic        done_o;
    logic [31:0] freq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit mon_en   = 1'b0;
    longint unsigned held = 0;

    always #10 clk = ~clk;

    clkrd_freq_readback #(.FREQ_W(FREQ_W), .PROD_W(48)) i_clkrd_freq_readback (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .pll_ctrl_i(pll_ctrl), .pll_coef_i(pll_coef), .src_word_i(src_w),
        .src_div_i(src_div), .post_ctl_i(post_w), .use_pll_i(use_pll),
        .pll_ref_sel_i(ref_sel), .xtal_khz_i(xtal), .vco0_khz_i(vco0),
        .vco1_khz_i(vco1), .done_o(done_o), .freq_khz_o(freq_o)
    );

    task automatic check(input bit ok, input string req,
                         input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference of the requirements, in 64-bit arithmetic.
    function automatic longint unsigned model();
        longint unsigned src, refk, pp, mm, nn, s, sd, f;
        case (src_w[1:0])
            2'd0: src = (src_w[17:16] == 2'b11) ? 108000 : longint'(xtal);   // R2
            2'd1: src = 0;                                                  // R3
            2'd2: src = 100000;                                             // R3
            default: begin                                                  // R4
                sd = 2;
                if (src_div[31]) sd = (src_w[8] ? longint'(src_div[13:8]) : longint'(src_div[5:0])) + 2;
                src = (2 * (src_w[8] ? longint'(vco1) : longint'(vco0))) / sd;
            end
        endcase
        if (use_pll) begin
            refk = ref_sel ? src : longint'(xtal);
            pp   = ref_sel ? longint'(pll_coef[21:16]) : 1;
            mm   = longint'(pll_coef[7:0]);
            nn   = longint'(pll_coef[15:8]);
            if (!pll_ctrl[0] || mm == 0 || pp == 0) s = 0;                  // R7 R8
            else s = ((refk * nn / mm) / pp) & M32;                         // R5 R6
        end else begin
            s = src;
        end
        if (post_w[31]) begin                                               // R9
            f = use_pll ? longint'(post_w[13:8]) : longint'(post_w[5:0]);
            s = ((2 * s) / (f + 2)) & M32;
        end
        return s;
    endfunction

    // Held-value comparison on every clock (R10).
    always @(negedge clk) begin
        if (mon_en && rst_n && !done_o)
            check(longint'(freq_o) == held, "R10 hold", longint'(freq_o), held);
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wait_result(input string req, input longint unsigned exp);
        bit got = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (done_o) begin
                check(longint'(freq_o) == exp, req, longint'(freq_o), exp);
                held = exp;
                got  = 1'b1;
                break;
            end
        end
        if (!got) check(1'b0, {req, " timeout"}, 0, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R10 single pulse", longint'(done_o), 0);
    endtask

    task automatic run(input string req);
        longint unsigned exp = model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_result(req, exp);
    endtask

    initial begin
        longint unsigned exp_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done", longint'(done_o), 0);
        check(freq_o == 32'd0, "R1 freq", longint'(freq_o), 0);
        mon_en = 1'b1;

        src_w = 32'h0000_0000; run("R2 crystal");
        src_w = 32'h0003_0000; run("R2 fixed 108000");
        src_w = 32'h0001_0000; run("R2 one bit set keeps crystal");
        src_w = 32'h0000_0002; run("R3 fixed 100000");
        src_w = 32'h0000_0001; run("R3 code 1 zero");
        src_w = 32'h0000_0003; src_div = 32'h0000_0000; run("R4 vco0 default div");
        src_w = 32'h0000_0103; src_div = 32'h8000_0504; run("R4 vco1 high field");
        src_w = 32'h0000_0003; src_div = 32'h8000_0504; run("R4 vco0 low field");

        use_pll = 1'b1; ref_sel = 1'b0; pll_ctrl = 32'h1;
        pll_coef = 32'h003F_6403; run("R5 crystal pll ignores P");
        pll_coef = 32'h0000_6403; run("R5 crystal pll zero P field");
        ref_sel = 1'b1; src_w = 32'h2; pll_coef = 32'h0002_3204; run("R6 source-fed pll");
        src_w = 32'h0000_0103; src_div = 32'h8000_0300; pll_coef = 32'h0003_FF07;
        run("R6 vco-fed pll");
        xtal = 32'hFFFF_FFF0; ref_sel = 1'b0; pll_coef = 32'h0000_FF01;
        run("R6 wide product truncation");
        xtal = 32'd27000;
        pll_ctrl = 32'h0; pll_coef = 32'h0000_6403; run("R7 pll disabled");
        pll_ctrl = 32'h1; pll_coef = 32'h0001_6400; run("R8 zero M");
        ref_sel = 1'b1; src_w = 32'h2; pll_coef = 32'h0000_6404; run("R8 zero P");

        ref_sel = 1'b0; pll_coef = 32'h0000_6403; post_w = 32'h8000_0A03;
        run("R9 post on pll route");
        use_pll = 1'b0; src_w = 32'h0; run("R9 post on source route");
        post_w = 32'h0000_0A03; run("R9 post disabled");

        // R11: second start and input changes during a run have no effect.
        use_pll = 1'b1; ref_sel = 1'b1; src_w = 32'h0000_0003; src_div = 32'h0;
        pll_coef = 32'h0003_2805; post_w = 32'h8000_0200;
        exp_a = model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        src_w = 32'h2; pll_coef = 32'h0000_0101; post_w = 32'h0; use_pll = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_result("R11 start ignored while busy", exp_a);
        repeat (3) @(negedge clk);
        check(longint'(freq_o) == exp_a, "R11 result kept", longint'(freq_o), exp_a);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule